// File: doc/BRIEF.md
# Software-Loaded Translation Entry Lookup

This block resolves one effective address against the ways that a set-associative, software-filled translation buffer has already selected for it. Each way supplies an entry image: valid flag, address-space flag, translation ID, size code, effective page number, real page number and six permission bits. The block compares every image against the request in parallel. The request carries the effective address, the access kind, the privilege state, the instruction and data address-space bits and three process IDs.

Each entry is first judged on its own, as a miss, a hit or a fault. The first image in search order that is not a miss then decides the response: lowest array first, then lowest way within the array. The response is registered and appears one clock after the request. It carries a 2-bit status, the real address and the flat index of the deciding entry. The surrounding pipeline uses the status to continue the access or to raise an exception.

Top module: `tlbchk_lookup`

## Requirements
- R1: An image whose valid bit (bit 7 of the image) is 0 is always a miss, whatever its other fields hold.
- R2: A translation ID of zero matches any request. A nonzero ID matches when it equals the primary process ID. It also matches when it equals the second or third process ID, but each of those is tried only when it is itself nonzero.
- R3: The page covers 1 KiB times 4 raised to the size code. Arrays flagged variable in ARR_VAR take the size code from image bits 11:8. The other arrays ignore those bits and use their configured minimum from ARR_MIN_TSIZE (defaults: array 0 variable, array 1 fixed at code 2, a 16 KiB page).
- R4: With mask equal to the complement of (page size minus one), a page matches only when (EA AND mask) equals the stored page number. The real address is then (real page number AND mask) OR (EA AND NOT mask).
- R5: The address-space bit (bit 6) must equal the instruction bit for a fetch (kind 0) and the data bit for a data access (kind 1 read, 2 write, 3 treated as read). A difference makes the entry a miss.
- R6: User requests take rights from bits 0, 1 and 2 (read, write, execute). Supervisor requests take them from bits 3, 4 and 5 (read, write, execute).
- R7: Status codes are 0 hit, 1 miss, 2 data protection fault and 3 execute fault. A matching fetch without execute right gives 3. A matching read without read right, or a matching write without write right, gives 2.
- R8: Image e occupies bits e*ENT_W and up, with e = array*WAYS + way. The lowest-numbered image that is not a miss decides the response, even when it is a fault and a later image would hit.
- R9: rsp_valid is 0 after reset. It rises on the clock edge after a cycle with req_valid high and falls after a cycle with req_valid low.
- R10: On a miss both rsp_ra and rsp_idx are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ea | input | AW | Effective address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_user | input | 1 | 1 user state, 0 supervisor |
| req_ir | input | 1 | Instruction address-space bit |
| req_dr | input | 1 | Data address-space bit |
| req_pid0 | input | PID_W | Primary process ID |
| req_pid1 | input | PID_W | Second process ID, unused when zero |
| req_pid2 | input | PID_W | Third process ID, unused when zero |
| way_images | input | NARR*WAYS*ENT_W | Selected entry images, packed per R8 |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | Hit, miss or fault code |
| rsp_ra | output | AW | Real address |
| rsp_idx | output | IDX_W | Flat index of the deciding image |

## Verification
On every cycle the assertions check the response latency and idle behaviour, a clean address and index on a miss, and search order. For search order they confirm that the reported entry was not a miss and that no lower entry was a non-miss, using the per-entry classification the block exposes. They also check that a fetch never yields a data fault and a data access never yields an execute fault. Only the bench scenarios can show that the classification itself is right: ID sharing and zero-ID skipping, the page-size masking and real-address splice under both size sources, address-space matching and privilege-based rights selection. The bench checks these against an arithmetic model of the requirements, over directed cases and a broad sweep.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
  // field positions inside one entry image (low part, independent of widths)
  localparam int PERM_LO = 0;   // {sx,sw,sr,ux,uw,ur}
  localparam int TS_BIT  = 6;
  localparam int V_BIT   = 7;
  localparam int TSZ_LO  = 8;
  localparam int TSZ_W   = 4;
  localparam int TID_LO  = 12;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_HIT    = 2'd0,
    ST_MISS   = 2'd1,
    ST_PFAULT = 2'd2,
    ST_XFAULT = 2'd3
  } status_e;
endpackage

// File: rtl/tlbchk_entry_eval.sv
module tlbchk_entry_eval
  import tlbchk_pkg::*;
#(
  parameter int         AW        = 32,
  parameter int         PID_W     = 4,
  parameter bit         VAR_SIZE  = 1'b1,
  parameter logic [3:0] MIN_TSIZE = 4'd0,
  localparam int        ENT_W     = TID_LO + PID_W + 2 * AW
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [AW-1:0]    ea,
  input  logic [1:0]       kind,
  input  logic             user,
  input  logic             ir,
  input  logic             dr,
  input  logic [PID_W-1:0] pid0,
  input  logic [PID_W-1:0] pid1,
  input  logic [PID_W-1:0] pid2,
  output logic             nonmiss,
  output logic [1:0]       status,
  output logic [AW-1:0]    ra
);
  localparam int EPN_LO = TID_LO + PID_W;
  localparam int RPN_LO = EPN_LO + AW;

  // page mask: complement of (1 KiB * 4^tsz - 1); shifts past AW give 0
  function automatic logic [AW-1:0] page_mask(input logic [3:0] tsz);
    logic [AW-1:0] span;
    span = {{(AW-1){1'b0}}, 1'b1} << (10 + 2 * int'(tsz));
    return ~(span - {{(AW-1){1'b0}}, 1'b1});
  endfunction

  function automatic logic pid_hit(input logic [PID_W-1:0] tid,
                                   input logic [PID_W-1:0] p0,
                                   input logic [PID_W-1:0] p1,
                                   input logic [PID_W-1:0] p2);
    logic h;
    h = (tid == '0) || (tid == p0);
    if (p1 != '0) h = h || (tid == p1);
    if (p2 != '0) h = h || (tid == p2);
    return h;
  endfunction

  logic [3:0]       tsz;
  logic [AW-1:0]    mask;
  logic [PID_W-1:0] tid;
  logic [AW-1:0]    epn, rpn;
  logic [5:0]       perm;
  logic [2:0]       rights;   // {x,w,r}
  logic             is_fetch, as_ok, page_ok, match, allowed;

  always_comb begin
    tsz      = VAR_SIZE ? ent[TSZ_LO +: TSZ_W] : MIN_TSIZE;
    mask     = page_mask(tsz);
    tid      = ent[TID_LO +: PID_W];
    epn      = ent[EPN_LO +: AW];
    rpn      = ent[RPN_LO +: AW];
    perm     = ent[PERM_LO +: 6];
    is_fetch = (kind == K_FETCH);
    as_ok    = ent[TS_BIT] == (is_fetch ? ir : dr);
    page_ok  = (ea & mask) == epn;
    match    = ent[V_BIT] && pid_hit(tid, pid0, pid1, pid2) && page_ok && as_ok;
    rights   = user ? perm[2:0] : perm[5:3];
    if (is_fetch)             allowed = rights[2];
    else if (kind == K_WRITE) allowed = rights[1];
    else                      allowed = rights[0];
    nonmiss = match;
    if (!match)        status = ST_MISS;
    else if (allowed)  status = ST_HIT;
    else if (is_fetch) status = ST_XFAULT;
    else               status = ST_PFAULT;
    ra = (rpn & mask) | (ea & ~mask);
  end
endmodule

// File: rtl/tlbchk_prio.sv
module tlbchk_prio #(
  parameter int N     = 4,
  parameter int AW    = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    nonmiss,
  input  logic [2*N-1:0]  status_in,
  input  logic [N*AW-1:0] ra_in,
  output logic [1:0]      status,
  output logic [AW-1:0]   ra,
  output logic [IDX_W-1:0] idx
);
  // scan from the top so the lowest non-miss entry is written last
  always_comb begin
    status = 2'd1;
    ra     = '0;
    idx    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (nonmiss[i]) begin
        status = status_in[2*i +: 2];
        ra     = ra_in[i*AW +: AW];
        idx    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbchk_lookup.sv
module tlbchk_lookup
  import tlbchk_pkg::*;
#(
  parameter int               AW            = 32,
  parameter int               PID_W         = 4,
  parameter int               NARR          = 2,
  parameter int               WAYS          = 2,
  parameter logic [NARR-1:0]  ARR_VAR       = 2'b01,
  parameter logic [4*NARR-1:0] ARR_MIN_TSIZE = 8'h21,
  localparam int              N             = NARR * WAYS,
  localparam int              ENT_W         = TID_LO + PID_W + 2 * AW,
  localparam int              IDX_W         = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [AW-1:0]      req_ea,
  input  logic [1:0]         req_kind,
  input  logic               req_user,
  input  logic               req_ir,
  input  logic               req_dr,
  input  logic [PID_W-1:0]   req_pid0,
  input  logic [PID_W-1:0]   req_pid1,
  input  logic [PID_W-1:0]   req_pid2,
  input  logic [N*ENT_W-1:0] way_images,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [AW-1:0]      rsp_ra,
  output logic [IDX_W-1:0]   rsp_idx
);
  logic [N-1:0]    ent_nonmiss;   // per-entry classification, seen by checker
  logic [2*N-1:0]  ent_status;
  logic [N*AW-1:0] ent_ra;
  logic [1:0]      pick_status;
  logic [AW-1:0]   pick_ra;
  logic [IDX_W-1:0] pick_idx;

  for (genvar e = 0; e < N; e++) begin : g_ent
    localparam int A = e / WAYS;
    tlbchk_entry_eval #(
      .AW(AW), .PID_W(PID_W),
      .VAR_SIZE(ARR_VAR[A]),
      .MIN_TSIZE(ARR_MIN_TSIZE[4*A +: 4])
    ) u_eval (
      .ent    (way_images[e*ENT_W +: ENT_W]),
      .ea     (req_ea),
      .kind   (req_kind),
      .user   (req_user),
      .ir     (req_ir),
      .dr     (req_dr),
      .pid0   (req_pid0),
      .pid1   (req_pid1),
      .pid2   (req_pid2),
      .nonmiss(ent_nonmiss[e]),
      .status (ent_status[2*e +: 2]),
      .ra     (ent_ra[e*AW +: AW])
    );
  end

  tlbchk_prio #(.N(N), .AW(AW)) u_prio (
    .nonmiss  (ent_nonmiss),
    .status_in(ent_status),
    .ra_in    (ent_ra),
    .status   (pick_status),
    .ra       (pick_ra),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_ra     <= '0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= pick_status;
        rsp_ra     <= pick_ra;
        rsp_idx    <= pick_idx;
      end
    end
  end
endmodule

// File: rtl/tlbchk_lookup_chk.sv
module tlbchk_lookup_chk #(
  parameter int  N     = 4,
  parameter int  AW    = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [N-1:0]     ent_nonmiss,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [AW-1:0]    rsp_ra,
  input logic [IDX_W-1:0] rsp_idx
);
  logic [N-1:0] nm_q;
  logic [1:0]   kind_q;
  logic [N-1:0] below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nm_q   <= '0;
      kind_q <= 2'd0;
    end else begin
      nm_q   <= ent_nonmiss;
      kind_q <= req_kind;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) below[i] = (i < int'(rsp_idx));
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R9
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> (rsp_ra == '0 && rsp_idx == '0));  // R10
  AST_MISS_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> (nm_q == '0));  // R8
  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd1) |-> (nm_q[rsp_idx] && (nm_q & below) == '0));  // R8
  AST_FETCH_NO_PFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind_q == 2'd0) |-> (rsp_status != 2'd2));  // R7
  AST_DATA_NO_XFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind_q != 2'd0) |-> (rsp_status != 2'd3));  // R7
endmodule

bind tlbchk_lookup tlbchk_lookup_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .ent_nonmiss(ent_nonmiss), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_ra(rsp_ra), .rsp_idx(rsp_idx)
);

// File: tb/sim_tlbchk_lookup.sv
module sim_tlbchk_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int EW = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0, req_ir = 1'b0, req_dr = 1'b0;
  logic [3:0] req_pid0 = '0, req_pid1 = '0, req_pid2 = '0;
  logic [NE*EW-1:0] way_images;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [31:0] rsp_ra;
  logic [1:0] rsp_idx;

  // bench copy of entry fields
  logic       e_v[NE], e_ts[NE];
  logic [3:0] e_tid[NE], e_tsz[NE];
  logic [31:0] e_epn[NE], e_rpn[NE];
  logic [5:0] e_perm[NE];

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbchk_lookup u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_kind(req_kind), .req_user(req_user), .req_ir(req_ir), .req_dr(req_dr),
    .req_pid0(req_pid0), .req_pid1(req_pid1), .req_pid2(req_pid2),
    .way_images(way_images), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_ra(rsp_ra), .rsp_idx(rsp_idx)
  );

  always_comb begin
    for (int e = 0; e < NE; e++)
      way_images[e*EW +: EW] = {e_rpn[e], e_epn[e], e_tid[e], e_tsz[e], e_v[e], e_ts[e], e_perm[e]};
  end

  function automatic logic [31:0] bmask(input int t);
    logic [63:0] sz;
    logic [63:0] m;
    sz = 64'd1 << (10 + 2 * t);
    m = ~(sz - 64'd1);
    return m[31:0];
  endfunction

  // arithmetic model of the requirements: returns {status, ra, idx}
  function automatic logic [35:0] model();
    for (int e = 0; e < NE; e++) begin
      int t;
      logic [31:0] m;
      logic pok, asb, hit, ok;
      logic [2:0] rt;
      t = (e / 2 == 0) ? int'(e_tsz[e]) : 2;
      m = bmask(t);
      pok = (e_tid[e] == 0) || (e_tid[e] == req_pid0) ||
            (req_pid1 != 0 && e_tid[e] == req_pid1) ||
            (req_pid2 != 0 && e_tid[e] == req_pid2);
      asb = (req_kind == 2'd0) ? req_ir : req_dr;
      hit = e_v[e] && pok && ((req_ea & m) == e_epn[e]) && (e_ts[e] == asb);
      if (hit) begin
        rt = req_user ? e_perm[e][2:0] : e_perm[e][5:3];
        ok = (req_kind == 2'd0) ? rt[2] : (req_kind == 2'd2) ? rt[1] : rt[0];
        return {(ok ? 2'd0 : (req_kind == 2'd0 ? 2'd3 : 2'd2)),
                (e_rpn[e] & m) | (req_ea & ~m), 2'(e)};
      end
    end
    return {2'd1, 32'd0, 2'd0};
  endfunction

  task automatic clear_all();
    for (int e = 0; e < NE; e++) begin
      e_v[e] = 0; e_ts[e] = 0; e_tid[e] = 0; e_tsz[e] = 0;
      e_epn[e] = 0; e_rpn[e] = 0; e_perm[e] = 0;
    end
  endtask

  task automatic set_ent(input int e, input logic v, input logic ts, input logic [3:0] tid,
                         input logic [3:0] tsz, input logic [31:0] epn,
                         input logic [31:0] rpn, input logic [5:0] perm);
    e_v[e] = v; e_ts[e] = ts; e_tid[e] = tid; e_tsz[e] = tsz;
    e_epn[e] = epn; e_rpn[e] = rpn; e_perm[e] = perm;
  endtask

  task automatic run(input logic [31:0] ea, input logic [1:0] kind, input logic user,
                     input logic ir, input logic dr, input logic [3:0] p0,
                     input logic [3:0] p1, input logic [3:0] p2);
    @(negedge clk);
    req_ea = ea; req_kind = kind; req_user = user; req_ir = ir; req_dr = dr;
    req_pid0 = p0; req_pid1 = p1; req_pid2 = p2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [1:0] st,
                            input logic [31:0] ra, input logic [1:0] idx);
    checks++;
    if (!rsp_valid || rsp_status != st || rsp_ra != ra || rsp_idx != idx) begin
      fails++;
      $display("FAIL %s: got v=%0b st=%0d ra=%h idx=%0d, expected v=1 st=%0d ra=%h idx=%0d",
               tag, rsp_valid, rsp_status, rsp_ra, rsp_idx, st, ra, idx);
    end
  endtask

  task automatic expect_model(input string tag);
    logic [35:0] x;
    x = model();
    expect_rsp(tag, x[35:34], x[33:2], x[1:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R9 reset: got %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;

    // R1: invalid entry never matches
    clear_all();
    set_ent(0, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_5000, 6'h3f);
    run(32'h0000_1010, 2'd1, 0, 0, 0, 4'd5, 0, 0);
    expect_rsp("R1 invalid", 2'd1, 32'h0, 2'd0);
    e_v[0] = 1;
    run(32'h0000_1010, 2'd1, 0, 0, 0, 4'd5, 0, 0);
    expect_rsp("R1 valid", 2'd0, 32'h0000_5010, 2'd0);

    // R2: process ID matching
    clear_all();
    set_ent(1, 1, 0, 4'd7, 0, 32'h0000_2000, 32'h0000_6000, 6'h3f);
    run(32'h0000_2004, 2'd1, 0, 0, 0, 4'd5, 0, 0);
    expect_rsp("R2 tid mismatch", 2'd1, 32'h0, 2'd0);
    run(32'h0000_2004, 2'd1, 0, 0, 0, 4'd5, 4'd7, 0);
    expect_rsp("R2 second pid", 2'd0, 32'h0000_6004, 2'd1);
    run(32'h0000_2004, 2'd1, 0, 0, 0, 4'd5, 0, 4'd7);
    expect_rsp("R2 third pid", 2'd0, 32'h0000_6004, 2'd1);
    e_tid[1] = 0;
    run(32'h0000_2004, 2'd1, 0, 0, 0, 4'd5, 0, 0);
    expect_rsp("R2 global tid", 2'd0, 32'h0000_6004, 2'd1);

    // R3: size source per array
    clear_all();
    set_ent(2, 1, 0, 0, 4'd0, 32'h0004_0000, 32'h0009_0000, 6'h3f);
    run(32'h0004_1234, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R3 fixed size", 2'd0, 32'h0009_1234, 2'd2);
    clear_all();
    set_ent(0, 1, 0, 0, 4'd1, 32'h0001_0000, 32'h0ABC_D000, 6'h3f);
    run(32'h0001_0A55, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R3 variable size in", 2'd0, 32'h0ABC_DA55, 2'd0);
    run(32'h0001_1A55, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R3 variable size out", 2'd1, 32'h0, 2'd0);

    // R4: smallest page, address splice
    clear_all();
    set_ent(0, 1, 0, 0, 4'd0, 32'h2000_0400, 32'h3000_0800, 6'h3f);
    run(32'h2000_07FF, 2'd2, 0, 0, 0, 0, 0, 0);
    expect_rsp("R4 splice", 2'd0, 32'h3000_0BFF, 2'd0);
    run(32'h2000_0800, 2'd2, 0, 0, 0, 0, 0, 0);
    expect_rsp("R4 page edge", 2'd1, 32'h0, 2'd0);

    // R5: address-space bit
    clear_all();
    set_ent(0, 1, 1, 0, 4'd0, 32'h0000_0400, 32'h0000_0C00, 6'h3f);
    run(32'h0000_0410, 2'd0, 0, 0, 1, 0, 0, 0);
    expect_rsp("R5 fetch uses ir", 2'd1, 32'h0, 2'd0);
    run(32'h0000_0410, 2'd0, 0, 1, 0, 0, 0, 0);
    expect_rsp("R5 fetch ir match", 2'd0, 32'h0000_0C10, 2'd0);
    run(32'h0000_0410, 2'd1, 0, 1, 0, 0, 0, 0);
    expect_rsp("R5 data uses dr", 2'd1, 32'h0, 2'd0);
    run(32'h0000_0410, 2'd3, 0, 0, 1, 0, 0, 0);
    expect_rsp("R5 kind3 as read", 2'd0, 32'h0000_0C10, 2'd0);

    // R6: privilege selects rights
    e_ts[0] = 0; e_perm[0] = 6'b111_000;
    run(32'h0000_0420, 2'd1, 1, 0, 0, 0, 0, 0);
    expect_rsp("R6 user lacks", 2'd2, 32'h0000_0C20, 2'd0);
    run(32'h0000_0420, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R6 supervisor has", 2'd0, 32'h0000_0C20, 2'd0);
    e_perm[0] = 6'b000_111;
    run(32'h0000_0420, 2'd0, 0, 0, 0, 0, 0, 0);
    expect_rsp("R6 supervisor no exec", 2'd3, 32'h0000_0C20, 2'd0);

    // R7: fault codes
    e_perm[0] = 6'b101_101;
    run(32'h0000_0420, 2'd2, 1, 0, 0, 0, 0, 0);
    expect_rsp("R7 write fault", 2'd2, 32'h0000_0C20, 2'd0);
    e_perm[0] = 6'b011_011;
    run(32'h0000_0420, 2'd0, 1, 0, 0, 0, 0, 0);
    expect_rsp("R7 exec fault", 2'd3, 32'h0000_0C20, 2'd0);

    // R8: search order
    clear_all();
    set_ent(1, 1, 0, 0, 4'd0, 32'h0000_8000, 32'h0001_0000, 6'b000_000);
    set_ent(2, 1, 0, 0, 4'd0, 32'h0000_8000, 32'h0002_0000, 6'h3f);
    run(32'h0000_8008, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R8 fault before hit", 2'd2, 32'h0001_0008, 2'd1);
    e_perm[1] = 6'h3f;
    set_ent(3, 1, 0, 0, 4'd0, 32'h0000_8000, 32'h0003_0000, 6'h3f);
    run(32'h0000_8008, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R8 lower way wins", 2'd0, 32'h0001_0008, 2'd1);

    // R10 and R9 idle
    run(32'h0F00_0000, 2'd1, 0, 0, 0, 0, 0, 0);
    expect_rsp("R10 miss clean", 2'd1, 32'h0, 2'd0);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R9 idle: got %b expected 0", rsp_valid);
    end

    // broad sweep against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ea;
      ea = $urandom;
      for (int e = 0; e < NE; e++) begin
        int t;
        logic [31:0] m;
        e_tsz[e] = 4'($urandom_range(0, 3));
        t = (e / 2 == 0) ? int'(e_tsz[e]) : 2;
        m = bmask(t);
        e_v[e] = ($urandom_range(0, 3) != 0);
        e_ts[e] = 1'($urandom);
        e_tid[e] = 4'($urandom_range(0, 3));
        e_epn[e] = ($urandom_range(0, 3) != 0) ? (ea & m) : ($urandom & m);
        e_rpn[e] = $urandom;
        e_perm[e] = 6'($urandom);
      end
      run(ea, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
      expect_model("R8 sweep R2 R3 R4 R5 R6 R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule